// File: doc/BRIEF.md
# Fly-By Cycle-Stealing DMA Controller

This block moves a block of words between one I/O port and memory without the processor taking part. Software first loads a memory address, a word count and a device address through a small register port. It then sets the direction and a start bit in the control register, and goes on with other work. For each word the controller requests the bus. When the grant arrives it uses exactly one bus cycle to drive the memory address, the device address and a matching pair of read/write strobes. It then drops its request and hands the bus back. The processor is never interrupted by this. It only stalls if it needs the bus during one of those stolen cycles.

The transfer is fly-by. The memory and the device exchange the data over the shared bus directly, and the controller holds no data register. After each word the memory address advances by one word (WORD_BYTES) and the count drops by one. When the count reaches zero the controller clears its busy status and raises an interrupt. The interrupt stays high until software clears it or starts a new transfer. A start with a count of zero completes at once and never touches the bus.

Register map, with offsets on `cfg_addr`:
- 0 is control. On a write, bit 0 starts a transfer, bit 1 is the direction (1 = device to memory) and bit 2 clears the interrupt. On a read, bit 0 is busy, bit 1 is the direction and bit 2 is the pending interrupt.
- 1 is the memory address.
- 2 is the remaining word count.
- 3 is the device address.

Registers 1 and 2 read back their live values while a transfer runs.

Top module: `flyby_dma`

## Requirements
- R1: While idle, a write to offset 1, 2 or 3 loads the memory address, the word count or the device address. A write to offset 0 loads the direction from bit 1. Each of these reads back the written value: offsets 1, 2 and 3 return the register, and offset 0 returns the direction in bit 1.
- R2: A start while idle with a nonzero count sets busy (offset 0, bit 0) from the next cycle. Busy stays set until the cycle after the last word's strobe. `bus_req` is never high while busy is clear.
- R3: `bus_req` is high while a word is waiting for the bus. A word's strobes are driven only in the cycle after `bus_gnt` was sampled high with `bus_req` high. Each grant moves exactly one word, and `bus_req` is low in the cycle after every strobe.
- R4: With direction 1 a word drives `dev_rd` and `mem_wr`. With direction 0 it drives `mem_rd` and `dev_wr`. No other combination of strobes occurs.
- R5: The k-th word (counting from 0) drives `mem_addr` = start address + k*WORD_BYTES, modulo 2^AW. Every word drives `dev_addr` = the programmed device address.
- R6: A transfer of N words produces exactly N strobes. Afterwards offset 2 reads 0 and offset 1 reads start + N*WORD_BYTES.
- R7: `irq` (and offset 0, bit 2) rises when the last word completes and stays high until a control write with bit 2 or bit 0 set. It is low during every strobe of a transfer, and a start clears it.
- R8: A start with count 0 sets `irq` in the next cycle, never sets busy and produces no strobe.
- R9: While busy, writes to offsets 1, 2 and 3 are ignored, as are direction and start writes to offset 0. The running transfer keeps its addresses, direction and word total.
- R10: After reset, `bus_req`, all strobes and `irq` are low, busy is clear, and offsets 0, 1 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register offset for reads and writes |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data for the offset on cfg_addr |
| bus_req | output | 1 | Request for one bus cycle |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Memory address of the current word |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| dev_addr | output | DAW | Device address |
| dev_rd | output | 1 | Device read strobe (device drives bus) |
| dev_wr | output | 1 | Device write strobe (device takes bus) |
| irq | output | 1 | Completion interrupt, held until cleared |

## Verification
The hardest state to reach is a transfer caught partway through with its registers being overwritten. The bench stretches one transfer with a slow grant so that it lasts about thirty cycles. During that window it writes new memory, count and device addresses, then a start with the opposite direction. The per-cycle monitor keeps checking every later strobe against the original programming. The other hard case is the bus boundary: the sweep covers every count of a 4-bit counter with grant delays of zero to two cycles. Start addresses are placed so that the memory address wraps past the top of its range within one transfer.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2,
      ST_GAP  = 2'd3
   } fbd_state_e;

   localparam logic [1:0] OFS_CTRL  = 2'd0;
   localparam logic [1:0] OFS_MADDR = 2'd1;
   localparam logic [1:0] OFS_COUNT = 2'd2;
   localparam logic [1:0] OFS_DADDR = 2'd3;

   localparam int CTL_START = 0;
   localparam int CTL_DIR   = 1;
   localparam int CTL_CLR   = 2;

   typedef struct packed {
      logic start;
      logic clr;
      logic ld_maddr;
      logic ld_cnt;
   } fbd_cmd_t;

endpackage

// File: rtl/fbd_addrgen.sv
module fbd_addrgen #(
   parameter int AW         = 16,
   parameter int CW         = 16,
   parameter int CFG_W      = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_maddr,
   input  logic             ld_cnt,
   input  logic             step,
   input  logic [CFG_W-1:0] wdata,
   output logic [AW-1:0]    maddr_q,
   output logic [CW-1:0]    cnt_q,
   output logic             cnt_zero,
   output logic             cnt_last
);

   logic [AW-1:0] maddr_next;

   generate
      if (WORD_BYTES == 1) begin : g_unit_step
         assign maddr_next = maddr_q + AW'(1);
      end else begin : g_wide_step
         localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
         assign maddr_next = maddr_q + STEP;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         maddr_q <= '0;
      end else if (ld_maddr) begin
         maddr_q <= wdata[AW-1:0];
      end else if (step) begin
         maddr_q <= maddr_next;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld_cnt) begin
         cnt_q <= wdata[CW-1:0];
      end else if (step) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign cnt_zero = (cnt_q == '0);
   assign cnt_last = (cnt_q == CW'(1));

endmodule

// File: rtl/fbd_regif.sv
module fbd_regif
   import fbd_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int DAW   = 16,
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             busy,
   input  logic             irq,
   input  logic [AW-1:0]    maddr_q,
   input  logic [CW-1:0]    cnt_q,
   output logic [CFG_W-1:0] cfg_rdata,
   output fbd_cmd_t         cmd,
   output logic             dir_q,
   output logic [DAW-1:0]   daddr_q
);

   logic wr_ctrl;
   logic wr_idle;

   assign wr_ctrl = cfg_we && (cfg_addr == OFS_CTRL);
   assign wr_idle = cfg_we && !busy;

   always_comb begin
      cmd.start    = wr_ctrl && !busy && cfg_wdata[CTL_START];
      cmd.clr      = wr_ctrl && cfg_wdata[CTL_CLR];
      cmd.ld_maddr = wr_idle && (cfg_addr == OFS_MADDR);
      cmd.ld_cnt   = wr_idle && (cfg_addr == OFS_COUNT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
      end else if (wr_ctrl && !busy) begin
         dir_q <= cfg_wdata[CTL_DIR];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         daddr_q <= '0;
      end else if (wr_idle && (cfg_addr == OFS_DADDR)) begin
         daddr_q <= cfg_wdata[DAW-1:0];
      end
   end

   always_comb begin
      unique case (cfg_addr)
         OFS_CTRL:  cfg_rdata = {{(CFG_W-3){1'b0}}, irq, dir_q, busy};
         OFS_MADDR: cfg_rdata = CFG_W'(maddr_q);
         OFS_COUNT: cfg_rdata = CFG_W'(cnt_q);
         default:   cfg_rdata = CFG_W'(daddr_q);
      endcase
   end

endmodule

// File: rtl/fbd_seq.sv
module fbd_seq
   import fbd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clr,
   input  logic cnt_zero,
   input  logic cnt_last,
   input  logic bus_gnt,
   output logic bus_req,
   output logic xfer,
   output logic busy,
   output logic irq
);

   fbd_state_e state_q;
   fbd_state_e state_d;
   logic       irq_set;
   logic       irq_d;

   always_comb begin
      state_d = state_q;
      irq_set = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               if (cnt_zero) irq_set = 1'b1;
               else          state_d = ST_REQ;
            end
         end
         ST_REQ: begin
            if (bus_gnt) state_d = ST_XFER;
         end
         ST_XFER: begin
            if (cnt_last) begin
               state_d = ST_IDLE;
               irq_set = 1'b1;
            end else begin
               state_d = ST_GAP;
            end
         end
         default: state_d = ST_REQ;
      endcase
   end

   always_comb begin
      irq_d = irq;
      if (clr || start) irq_d = 1'b0;
      if (irq_set)      irq_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         irq     <= 1'b0;
      end else begin
         state_q <= state_d;
         irq     <= irq_d;
      end
   end

   assign bus_req = (state_q == ST_REQ) || (state_q == ST_XFER);
   assign xfer    = (state_q == ST_XFER);
   assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
   import fbd_pkg::*;
#(
   parameter int AW         = 16,
   parameter int CW         = 16,
   parameter int DAW        = 16,
   parameter int CFG_W      = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [DAW-1:0]   dev_addr,
   output logic             dev_rd,
   output logic             dev_wr,
   output logic             irq
);

   initial begin
      if (CFG_W < AW || CFG_W < CW || CFG_W < DAW || CFG_W < 4)
         $fatal(1, "flyby_dma: CFG_W narrower than a register");
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0)
         $fatal(1, "flyby_dma: WORD_BYTES must be a power of two");
      if (CW < 1 || AW < 1 || DAW < 1)
         $fatal(1, "flyby_dma: widths must be positive");
   end

   fbd_cmd_t        cmd;
   logic            dir_q;
   logic [DAW-1:0]  daddr_q;
   logic [AW-1:0]   maddr_q;
   logic [CW-1:0]   cnt_q;
   logic            cnt_zero;
   logic            cnt_last;
   logic            xfer;
   logic            busy;

   fbd_regif #(.AW(AW), .CW(CW), .DAW(DAW), .CFG_W(CFG_W)) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .busy      (busy),
      .irq       (irq),
      .maddr_q   (maddr_q),
      .cnt_q     (cnt_q),
      .cfg_rdata (cfg_rdata),
      .cmd       (cmd),
      .dir_q     (dir_q),
      .daddr_q   (daddr_q)
   );

   fbd_addrgen #(.AW(AW), .CW(CW), .CFG_W(CFG_W), .WORD_BYTES(WORD_BYTES)) u_addrgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_maddr (cmd.ld_maddr),
      .ld_cnt   (cmd.ld_cnt),
      .step     (xfer),
      .wdata    (cfg_wdata),
      .maddr_q  (maddr_q),
      .cnt_q    (cnt_q),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last)
   );

   fbd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cmd.start),
      .clr      (cmd.clr),
      .cnt_zero (cnt_zero),
      .cnt_last (cnt_last),
      .bus_gnt  (bus_gnt),
      .bus_req  (bus_req),
      .xfer     (xfer),
      .busy     (busy),
      .irq      (irq)
   );

   assign mem_addr = maddr_q;
   assign dev_addr = daddr_q;
   assign mem_rd   = xfer && !dir_q;
   assign dev_wr   = xfer && !dir_q;
   assign mem_wr   = xfer && dir_q;
   assign dev_rd   = xfer && dir_q;

endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
   parameter int DAW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ctl_wr,
   input logic           ctl_start,
   input logic           ctl_clr,
   input logic           bus_req,
   input logic           bus_gnt,
   input logic           mem_rd,
   input logic           mem_wr,
   input logic           dev_rd,
   input logic           dev_wr,
   input logic [DAW-1:0] dev_addr,
   input logic           irq,
   input logic           busy,
   input logic           cnt_zero
);

   logic strobe;
   assign strobe = mem_rd || mem_wr || dev_rd || dev_wr;

   AST_STROBE_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> ($past(bus_gnt) && $past(bus_req))); // R3

   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !bus_req); // R3

   AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr == dev_rd) && (mem_rd == dev_wr) && !(mem_rd && mem_wr)); // R4

   AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req); // R2

   AST_IRQ_LOW_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !irq); // R7

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(ctl_wr && (ctl_start || ctl_clr))) |=> irq); // R7

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_start && !busy && cnt_zero) |=> (irq && !busy)); // R8

   AST_DEV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(dev_addr)); // R9

endmodule

bind flyby_dma fbd_checker #(.DAW(DAW)) u_fbd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_wr    (cfg_we && (cfg_addr == 2'd0)),
   .ctl_start (cfg_wdata[0]),
   .ctl_clr   (cfg_wdata[2]),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .dev_rd    (dev_rd),
   .dev_wr    (dev_wr),
   .dev_addr  (dev_addr),
   .irq       (irq),
   .busy      (busy),
   .cnt_zero  (cnt_zero)
);

// File: tb/tb_flyby_dma.sv
`timescale 1ns/1ps
module tb_flyby_dma;

   localparam int AW = 8;
   localparam int CW = 4;
   localparam int DAW = 3;
   localparam int CFG_W = 8;
   localparam int WB = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_addr = 2'd0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic [CFG_W-1:0] cfg_rdata;
   logic             bus_req;
   logic             bus_gnt = 1'b0;
   logic [AW-1:0]    mem_addr;
   logic             mem_rd, mem_wr, dev_rd, dev_wr;
   logic [DAW-1:0]   dev_addr;
   logic             irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [AW-1:0]  exp_maddr = '0;
   logic [DAW-1:0] exp_dev = '0;
   logic           exp_dir = 1'b0;
   int             strobe_cnt = 0;
   int             gdelay = 0;
   int             wait_cnt = 0;
   bit             prev_gnt = 0;
   bit             prev_req = 0;
   bit             req_chk = 0;

   always #2.5 clk = ~clk;

   flyby_dma #(.AW(AW), .CW(CW), .DAW(DAW), .CFG_W(CFG_W), .WORD_BYTES(WB)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Bus monitor and grant model, one place at the falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (req_chk) begin
            chk(!bus_req, "R3 req low after strobe", int'(bus_req), 0);
            req_chk = 0;
         end
         if (mem_rd || mem_wr || dev_rd || dev_wr) begin
            chk(prev_gnt && prev_req, "R3 strobe follows grant", int'(prev_gnt), 1);
            chk(exp_dir ? (dev_rd && mem_wr && !mem_rd && !dev_wr)
                        : (mem_rd && dev_wr && !mem_wr && !dev_rd),
                "R4 strobe pair", int'({mem_rd, mem_wr, dev_rd, dev_wr}),
                exp_dir ? 'h6 : 'h9);
            chk(mem_addr == exp_maddr, "R5 mem_addr", int'(mem_addr), int'(exp_maddr));
            chk(dev_addr == exp_dev, "R5 dev_addr", int'(dev_addr), int'(exp_dev));
            chk(!irq, "R7 irq low during strobe", int'(irq), 0);
            exp_maddr = exp_maddr + AW'(WB);
            strobe_cnt++;
            req_chk = 1;
         end
      end
      if (!bus_req) begin
         bus_gnt = 1'b0;
         wait_cnt = 0;
      end else if (!bus_gnt) begin
         if (wait_cnt >= gdelay) bus_gnt = 1'b1;
         else wait_cnt++;
      end
      prev_gnt = bus_gnt;
      prev_req = bus_req;
   end

   task automatic cfg_write(input logic [1:0] a, input logic [CFG_W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [1:0] a, output logic [CFG_W-1:0] d);
      cfg_addr = a;
      #0.5;
      d = cfg_rdata;
   endtask

   task automatic wait_idle();
      logic [CFG_W-1:0] r;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         cfg_read(2'd0, r);
         if (!r[0]) return;
      end
      chk(0, "R2 busy never cleared", 1, 0);
   endtask

   task automatic run(input bit dir, input logic [AW-1:0] base,
                      input logic [DAW-1:0] dev, input int n, input int gd,
                      input bit irq_before);
      logic [CFG_W-1:0] r;
      gdelay = gd;
      cfg_write(2'd1, CFG_W'(base));
      cfg_write(2'd2, CFG_W'(n));
      cfg_write(2'd3, CFG_W'(dev));
      cfg_read(2'd1, r); chk(r == CFG_W'(base), "R1 maddr readback", int'(r), int'(base));
      cfg_read(2'd2, r); chk(r == CFG_W'(n), "R1 count readback", int'(r), n);
      cfg_read(2'd3, r); chk(r == CFG_W'(dev), "R1 dev readback", int'(r), int'(dev));
      chk(irq == irq_before, "R7 irq held over programming", int'(irq), int'(irq_before));
      exp_maddr = base; exp_dev = dev; exp_dir = dir; strobe_cnt = 0;
      cfg_write(2'd0, CFG_W'({1'b0, dir, 1'b1}));
      cfg_read(2'd0, r);
      if (n == 0)
         chk(r[2:0] == {1'b1, dir, 1'b0}, "R8 zero count done at once", int'(r[2:0]),
             int'({1'b1, dir, 1'b0}));
      else
         chk(r[2:0] == {1'b0, dir, 1'b1}, "R2 busy after start R7 irq cleared",
             int'(r[2:0]), int'({1'b0, dir, 1'b1}));
      wait_idle();
      @(negedge clk);
      chk(strobe_cnt == n, "R6 word total", strobe_cnt, n);
      chk(irq == 1'b1, "R7 irq at completion", int'(irq), 1);
      cfg_read(2'd2, r); chk(r == '0, "R6 count ends at zero", int'(r), 0);
      cfg_read(2'd1, r);
      chk(r == CFG_W'(base + AW'(n * WB)), "R6 final address", int'(r),
          int'(base + AW'(n * WB)));
      cfg_read(2'd0, r); chk(r[1] == dir, "R1 direction readback", int'(r[1]), int'(dir));
   endtask

   initial begin
      logic [CFG_W-1:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({bus_req, mem_rd, mem_wr, dev_rd, dev_wr, irq} == '0, "R10 outputs low",
          int'({bus_req, mem_rd, mem_wr, dev_rd, dev_wr, irq}), 0);
      cfg_read(2'd0, r); chk(r == '0, "R10 ctrl", int'(r), 0);
      cfg_read(2'd1, r); chk(r == '0, "R10 maddr", int'(r), 0);
      cfg_read(2'd2, r); chk(r == '0, "R10 count", int'(r), 0);

      // Sweep every count, both directions, grant delays 0..2, with wraps.
      for (int d = 0; d < 2; d++) begin
         for (int n = 0; n < 16; n++) begin
            run(d[0], AW'(8'hE0 + n * 7 + d * 3), DAW'(n + d), n, (n + d) % 3,
                !(d == 0 && n == 0));
         end
      end

      // R7 clear by control bit 2, no start triggered.
      cfg_write(2'd0, CFG_W'(8'h04));
      cfg_read(2'd0, r);
      chk(r[2:0] == 3'b000, "R7 irq cleared", int'(r[2:0]), 0);
      chk(!irq, "R7 irq port cleared", int'(irq), 0);
      repeat (3) @(negedge clk);
      chk(!bus_req && !irq, "R7 clear does not start", int'(bus_req), 0);

      // R9 writes while busy are ignored.
      gdelay = 3;
      cfg_write(2'd1, CFG_W'(8'h10));
      cfg_write(2'd2, CFG_W'(6));
      cfg_write(2'd3, CFG_W'(5));
      exp_maddr = 8'h10; exp_dev = 3'd5; exp_dir = 1'b1; strobe_cnt = 0;
      cfg_write(2'd0, CFG_W'(8'h03));
      cfg_write(2'd1, CFG_W'(8'hAA));
      cfg_write(2'd2, CFG_W'(3));
      cfg_write(2'd3, CFG_W'(1));
      cfg_write(2'd0, CFG_W'(8'h01));
      cfg_read(2'd0, r);
      chk(r[1:0] == 2'b11, "R9 busy and direction kept", int'(r[1:0]), 3);
      wait_idle();
      @(negedge clk);
      chk(strobe_cnt == 6, "R9 word total kept", strobe_cnt, 6);
      cfg_read(2'd1, r);
      chk(r == CFG_W'(8'h1C), "R9 address kept", int'(r), 'h1C);
      cfg_read(2'd3, r);
      chk(r == CFG_W'(5), "R9 device kept", int'(r), 5);
      chk(irq, "R7 irq after protected run", int'(irq), 1);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=0 exp=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule